// File: doc/BRIEF.md
# Address Translation Request Coalescer

This block sits between several translation requesters and a single TLB lookup port. A request is merged into an existing entry when both fall in the same virtual page and the same time bucket. The bucket is the requester's issue cycle divided by a window length. Each merged group becomes one lookup. Lookups leave through a fixed number of lanes, which caps the probes sent per cycle. The oldest bucket goes first, and within a bucket the first to arrive goes first.

An issued group stays in an outstanding table until the TLB answers with its entry index and physical page number. The answered index is queued for cleanup. A fan-out stage then walks the merged slots of the entry at the head of that queue, one per cycle. Each slot returns the physical page joined with its own page offset, on its own port and with its own tag. After the last slot, the entry is freed. When no entry and no merge slot can take a request, the input is backpressured. A lookup the TLB refuses stays offered until it is taken.

Top module: `tlb_req_coalescer`

## Requirements
- R1: With merging enabled, requests that share the virtual page (address bits above the 12 offset bits) and the bucket produce exactly one accepted lookup. Each of them still receives one response.
- R2: Requests in different buckets (issue cycle divided by WIN) never merge, even when they fall in the same page.
- R3: At most PROBES lookups are offered per cycle, lane 0 first. Lanes are ordered by ascending bucket, and within a bucket by order of arrival. An entry is offered only once its bucket is older than the current bucket of the block's own cycle count.
- R4: While `merge_dis_i` is high, every accepted request allocates its own entry and its own lookup.
- R5: A lookup offered while `lk_ready_i` is low stays pending and is offered again until it is accepted. No lookup is lost or sent twice.
- R6: On a translation response for entry `tr_id_i`, the merged requests are answered one per cycle in merge order, starting in the cycle after the response. Each answer carries the port, the tag, and `{tr_ppn_i, own offset}`.
- R7: Each entry holds at most MERGE requests. A further matching request opens a new entry. When no free entry exists and no entry can merge the request, `req_ready_o` stays low.
- R8: At most one request is accepted per cycle. The lowest-numbered valid port is served first.
- R9: `n_req_o` counts accepted requests and `n_lkp_o` counts accepted lookups.
- R10: After reset, no lookup and no response is valid, and both counters are zero.
- R11: An entry is freed after its last answer, so a backpressured request is accepted once earlier groups complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| merge_dis_i | input | 1 | Turns merging off |
| req_valid_i | input | N_PORTS | Request valid per port |
| req_ready_o | output | N_PORTS | Request accepted per port |
| req_vaddr_i | input | N_PORTS x VA_W | Virtual address per port |
| req_tag_i | input | N_PORTS x TAG_W | Requester tag per port |
| req_cycle_i | input | N_PORTS x CYC_W | Issue cycle per port |
| lk_valid_o | output | PROBES | Lookup lane valid |
| lk_ready_i | input | 1 | TLB takes all valid lanes this cycle |
| lk_vpn_o | output | PROBES x VPN_W | Virtual page per lane |
| lk_id_o | output | PROBES x E_W | Entry index per lane |
| tr_valid_i | input | 1 | Translation response valid |
| tr_id_i | input | E_W | Entry index of the response |
| tr_ppn_i | input | PPN_W | Physical page number |
| rsp_valid_o | output | N_PORTS | Response valid per port |
| rsp_paddr_o | output | N_PORTS x PA_W | Physical address per port |
| rsp_tag_o | output | N_PORTS x TAG_W | Tag per port |
| n_req_o | output | CNT_W | Accepted request count |
| n_lkp_o | output | CNT_W | Accepted lookup count |

## Verification
A corrupted merge slot shows up a few cycles after the TLB answers, as a wrong offset, tag or port on a response. A lost or stuck issue flag shows up as a missing response, which the bench's outstanding count exposes when it drains, or as a lookup count that does not match the lookups the TLB model took. An ordering fault shows directly on the lookup lanes in the cycle after the held lookups are loaded. A free-list fault shows as an input that stays blocked after the table empties.

// File: rtl/tlbc_pkg.sv
package tlbc_pkg;
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tlbc_in_arb.sv
module tlbc_in_arb #(
  parameter int unsigned N = 2,
  localparam int unsigned W = tlbc_pkg::idx_w(N)
) (
  input  logic [N-1:0] valid_i,
  output logic [N-1:0] gnt_o,
  output logic [W-1:0] idx_o,
  output logic         any_o
);
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    any_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (valid_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
        idx_o    = W'(i);
        any_o    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tlbc_issue_sel.sv
module tlbc_issue_sel #(
  parameter int unsigned E     = 4,
  parameter int unsigned P     = 2,
  parameter int unsigned KEY_W = 32,
  localparam int unsigned EW   = tlbc_pkg::idx_w(E)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [E-1:0]            elig_i,
  input  logic [E-1:0][KEY_W-1:0] key_i,
  output logic [P-1:0]            vld_o,
  output logic [P-1:0][EW-1:0]    id_o
);
  // lane k takes the k-th smallest key among eligible entries
  always_comb begin
    logic [E-1:0]     taken;
    logic [KEY_W-1:0] best;
    taken = '0;
    for (int k = 0; k < P; k++) begin
      vld_o[k] = 1'b0;
      id_o[k]  = '0;
      best     = '0;
      for (int e = 0; e < E; e++) begin
        if (elig_i[e] && !taken[e] && (!vld_o[k] || key_i[e] < best)) begin
          vld_o[k] = 1'b1;
          id_o[k]  = EW'(e);
          best     = key_i[e];
        end
      end
      if (vld_o[k]) taken[id_o[k]] = 1'b1;
    end
  end

  for (genvar k = 1; k < P; k++) begin : g_ord
    p_lane_order_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_o[k] |-> (vld_o[k-1] && (key_i[id_o[k-1]] < key_i[id_o[k]])));
  end
endmodule

// File: rtl/tlbc_fifo.sv
module tlbc_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 2,
  localparam int unsigned AW   = tlbc_pkg::idx_w(DEPTH),
  localparam int unsigned CW   = tlbc_pkg::idx_w(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign head_o  = mem_q[rd_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (push_i) begin
        mem_q[wr_q] <= data_i;
        wr_q        <= nxt(wr_q);
      end
      if (pop_i) rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  p_no_overflow_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o) |-> pop_i);
  p_no_underflow_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/tlb_req_coalescer.sv
module tlb_req_coalescer #(
  parameter int unsigned N_PORTS = 2,
  parameter int unsigned PROBES  = 2,
  parameter int unsigned WIN     = 1,
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned MERGE   = 4,
  parameter int unsigned VA_W    = 32,
  parameter int unsigned PG_W    = 12,
  parameter int unsigned PPN_W   = 20,
  parameter int unsigned TAG_W   = 6,
  parameter int unsigned CYC_W   = 16,
  parameter int unsigned CNT_W   = 16,
  localparam int unsigned VPN_W  = VA_W - PG_W,
  localparam int unsigned PA_W   = PPN_W + PG_W,
  localparam int unsigned E_W    = tlbc_pkg::idx_w(ENTRIES)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            merge_dis_i,
  input  logic [N_PORTS-1:0]              req_valid_i,
  output logic [N_PORTS-1:0]              req_ready_o,
  input  logic [N_PORTS-1:0][VA_W-1:0]    req_vaddr_i,
  input  logic [N_PORTS-1:0][TAG_W-1:0]   req_tag_i,
  input  logic [N_PORTS-1:0][CYC_W-1:0]   req_cycle_i,
  output logic [PROBES-1:0]               lk_valid_o,
  input  logic                            lk_ready_i,
  output logic [PROBES-1:0][VPN_W-1:0]    lk_vpn_o,
  output logic [PROBES-1:0][E_W-1:0]      lk_id_o,
  input  logic                            tr_valid_i,
  input  logic [E_W-1:0]                  tr_id_i,
  input  logic [PPN_W-1:0]                tr_ppn_i,
  output logic [N_PORTS-1:0]              rsp_valid_o,
  output logic [N_PORTS-1:0][PA_W-1:0]    rsp_paddr_o,
  output logic [N_PORTS-1:0][TAG_W-1:0]   rsp_tag_o,
  output logic [CNT_W-1:0]                n_req_o,
  output logic [CNT_W-1:0]                n_lkp_o
);
  localparam int unsigned P_W   = tlbc_pkg::idx_w(N_PORTS);
  localparam int unsigned M_W   = tlbc_pkg::idx_w(MERGE + 1);
  localparam int unsigned S_W   = tlbc_pkg::idx_w(MERGE);
  localparam int unsigned KEY_W = 2 * CYC_W;

  // outstanding table
  logic [ENTRIES-1:0] ent_vld_q, ent_iss_q, ent_rsp_q;
  logic [VPN_W-1:0]   ent_vpn_q [ENTRIES];
  logic [CYC_W-1:0]   ent_bkt_q [ENTRIES];
  logic [CYC_W-1:0]   ent_seq_q [ENTRIES];
  logic [M_W-1:0]     ent_cnt_q [ENTRIES];
  logic [PPN_W-1:0]   ent_ppn_q [ENTRIES];
  logic [P_W-1:0]     slot_port_q [ENTRIES][MERGE];
  logic [TAG_W-1:0]   slot_tag_q  [ENTRIES][MERGE];
  logic [PG_W-1:0]    slot_off_q  [ENTRIES][MERGE];

  logic [CYC_W-1:0] now_q, seq_q;
  logic [S_W-1:0]   fo_idx_q;
  logic [CNT_W-1:0] n_req_q, n_lkp_q;

  // intake
  logic [N_PORTS-1:0] in_gnt;
  logic [P_W-1:0]     in_idx;
  logic               in_any;

  tlbc_in_arb #(.N(N_PORTS)) u_arb (
    .valid_i(req_valid_i), .gnt_o(in_gnt), .idx_o(in_idx), .any_o(in_any)
  );

  logic [VPN_W-1:0] in_vpn;
  logic [PG_W-1:0]  in_off;
  logic [CYC_W-1:0] in_bkt, now_bkt;
  logic             hit, has_free, accept;
  logic [E_W-1:0]   hit_id, free_id, tgt_id;

  assign in_vpn  = req_vaddr_i[in_idx][VA_W-1:PG_W];
  assign in_off  = req_vaddr_i[in_idx][PG_W-1:0];
  assign in_bkt  = req_cycle_i[in_idx] / CYC_W'(WIN);
  assign now_bkt = now_q / CYC_W'(WIN);

  always_comb begin
    hit      = 1'b0;
    hit_id   = '0;
    has_free = 1'b0;
    free_id  = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (ent_vld_q[e] && !ent_iss_q[e] && !merge_dis_i && ent_vpn_q[e] == in_vpn &&
          ent_bkt_q[e] == in_bkt && ent_cnt_q[e] < M_W'(MERGE)) begin
        hit    = 1'b1;
        hit_id = E_W'(e);
      end
      if (!ent_vld_q[e]) begin
        has_free = 1'b1;
        free_id  = E_W'(e);
      end
    end
  end

  assign accept      = in_any && (hit || has_free);
  assign tgt_id      = hit ? hit_id : free_id;
  assign req_ready_o = in_gnt & {N_PORTS{accept}};

  // issue lanes
  logic [ENTRIES-1:0]            elig;
  logic [ENTRIES-1:0][KEY_W-1:0] ent_key;
  logic [PROBES-1:0][E_W-1:0]    lane_id;

  always_comb begin
    for (int e = 0; e < ENTRIES; e++) begin
      elig[e]    = ent_vld_q[e] && !ent_iss_q[e] && (ent_bkt_q[e] < now_bkt);
      ent_key[e] = {ent_bkt_q[e], ent_seq_q[e]};
    end
  end

  tlbc_issue_sel #(.E(ENTRIES), .P(PROBES), .KEY_W(KEY_W)) u_sel (
    .clk_i(clk_i), .rst_ni(rst_ni), .elig_i(elig), .key_i(ent_key),
    .vld_o(lk_valid_o), .id_o(lane_id)
  );

  logic [CNT_W-1:0] lk_acc_n;
  always_comb begin
    lk_acc_n = '0;
    for (int k = 0; k < PROBES; k++) begin
      lk_id_o[k]  = lane_id[k];
      lk_vpn_o[k] = ent_vpn_q[lane_id[k]];
      if (lk_ready_i && lk_valid_o[k]) lk_acc_n = lk_acc_n + CNT_W'(1);
    end
  end

  // cleanup queue and fan-out
  logic [E_W-1:0] hd;
  logic           fq_empty, fq_full, fo_act, fo_last;

  tlbc_fifo #(.DEPTH(ENTRIES), .W(E_W)) u_cq (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(tr_valid_i), .data_i(tr_id_i),
    .pop_i(fo_act && fo_last), .head_o(hd), .empty_o(fq_empty), .full_o(fq_full)
  );

  assign fo_act  = !fq_empty;
  assign fo_last = (M_W'(fo_idx_q) == ent_cnt_q[hd] - M_W'(1));

  always_comb begin
    rsp_valid_o = '0;
    rsp_paddr_o = '0;
    rsp_tag_o   = '0;
    if (fo_act) begin
      rsp_valid_o[slot_port_q[hd][fo_idx_q]] = 1'b1;
      rsp_paddr_o[slot_port_q[hd][fo_idx_q]] = {ent_ppn_q[hd], slot_off_q[hd][fo_idx_q]};
      rsp_tag_o[slot_port_q[hd][fo_idx_q]]   = slot_tag_q[hd][fo_idx_q];
    end
  end

  logic [S_W-1:0] wslot;
  assign wslot = hit ? S_W'(ent_cnt_q[hit_id]) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_vld_q <= '0;
      ent_iss_q <= '0;
      ent_rsp_q <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        ent_vpn_q[e] <= '0;
        ent_bkt_q[e] <= '0;
        ent_seq_q[e] <= '0;
        ent_cnt_q[e] <= '0;
        ent_ppn_q[e] <= '0;
        for (int s = 0; s < MERGE; s++) begin
          slot_port_q[e][s] <= '0;
          slot_tag_q[e][s]  <= '0;
          slot_off_q[e][s]  <= '0;
        end
      end
      now_q    <= '0;
      seq_q    <= '0;
      fo_idx_q <= '0;
      n_req_q  <= '0;
      n_lkp_q  <= '0;
    end else begin
      now_q <= now_q + CYC_W'(1);
      if (accept) begin
        slot_port_q[tgt_id][wslot] <= in_idx;
        slot_tag_q[tgt_id][wslot]  <= req_tag_i[in_idx];
        slot_off_q[tgt_id][wslot]  <= in_off;
        n_req_q <= n_req_q + CNT_W'(1);
        if (hit) begin
          ent_cnt_q[hit_id] <= ent_cnt_q[hit_id] + M_W'(1);
        end else begin
          ent_vld_q[free_id] <= 1'b1;
          ent_iss_q[free_id] <= 1'b0;
          ent_rsp_q[free_id] <= 1'b0;
          ent_vpn_q[free_id] <= in_vpn;
          ent_bkt_q[free_id] <= in_bkt;
          ent_seq_q[free_id] <= seq_q;
          ent_cnt_q[free_id] <= M_W'(1);
          seq_q <= seq_q + CYC_W'(1);
        end
      end
      if (lk_ready_i) begin
        for (int k = 0; k < PROBES; k++)
          if (lk_valid_o[k]) ent_iss_q[lane_id[k]] <= 1'b1;
      end
      n_lkp_q <= n_lkp_q + lk_acc_n;
      if (tr_valid_i) begin
        ent_rsp_q[tr_id_i] <= 1'b1;
        ent_ppn_q[tr_id_i] <= tr_ppn_i;
      end
      if (fo_act) begin
        if (fo_last) begin
          ent_vld_q[hd] <= 1'b0;
          fo_idx_q      <= '0;
        end else begin
          fo_idx_q <= fo_idx_q + S_W'(1);
        end
      end
    end
  end

  assign n_req_o = n_req_q;
  assign n_lkp_o = n_lkp_q;

  p_ready_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_ready_o));
  p_rsp_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rsp_valid_o));
  p_rsp_answered_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fo_act |-> (ent_vld_q[hd] && ent_rsp_q[hd]));
  p_tr_issued_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tr_valid_i |-> (ent_vld_q[tr_id_i] && ent_iss_q[tr_id_i] && !ent_rsp_q[tr_id_i]));
  p_req_count_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (n_req_q != $past(n_req_q)));
  p_lane_stuck_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_o[0] && !lk_ready_i) |=> ent_vld_q[$past(lane_id[0])]);
  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    p_merge_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ent_vld_q[e] |-> (ent_cnt_q[e] != '0 && ent_cnt_q[e] <= M_W'(MERGE)));
  end
endmodule

// File: tb/sim_tlb_req_coalescer.sv
`timescale 1ns/1ps
module sim_tlb_req_coalescer;
  localparam int N = 2, P = 2, EW = 2, VA = 32, PA = 32, TAG = 6, CYC = 16, CW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic                   merge_dis = 1'b0;
  logic [N-1:0]           req_valid = '0, req_ready;
  logic [N-1:0][VA-1:0]   req_vaddr = '0;
  logic [N-1:0][TAG-1:0]  req_tag = '0;
  logic [N-1:0][CYC-1:0]  req_cycle = '0;
  logic [P-1:0]           lk_valid;
  logic                   lk_ready = 1'b0;
  logic [P-1:0][19:0]     lk_vpn;
  logic [P-1:0][EW-1:0]   lk_id;
  logic                   tr_valid = 1'b0;
  logic [EW-1:0]          tr_id = '0;
  logic [19:0]            tr_ppn = '0;
  logic [N-1:0]           rsp_valid;
  logic [N-1:0][PA-1:0]   rsp_paddr;
  logic [N-1:0][TAG-1:0]  rsp_tag;
  logic [CW-1:0]          n_req, n_lkp;

  tlb_req_coalescer u0 (
    .clk_i(clk), .rst_ni(rst_n), .merge_dis_i(merge_dis),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vaddr_i(req_vaddr),
    .req_tag_i(req_tag), .req_cycle_i(req_cycle),
    .lk_valid_o(lk_valid), .lk_ready_i(lk_ready), .lk_vpn_o(lk_vpn), .lk_id_o(lk_id),
    .tr_valid_i(tr_valid), .tr_id_i(tr_id), .tr_ppn_i(tr_ppn),
    .rsp_valid_o(rsp_valid), .rsp_paddr_o(rsp_paddr), .rsp_tag_o(rsp_tag),
    .n_req_o(n_req), .n_lkp_o(n_lkp)
  );

  int checks = 0, fails = 0, cyc = 0, wd = 0;
  bit pend [64];
  int pport [64];
  logic [VA-1:0] pva [64];
  int outstanding = 0, acc_total = 0, lk_total = 0;
  int rlog [4096];
  int rcnt = 0;
  int rdy_mode = 0;  // 0 random, 1 hold low, 2 always high
  logic [EW-1:0] tq_id [64];
  logic [19:0]   tq_vpn [64];
  int tq_h = 0, tq_t = 0;

  function automatic logic [19:0] xl(input logic [19:0] v);
    return v ^ 20'h5A5A5;
  endfunction

  task automatic chk(input bit ok, input string r, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // TLB model and response checker
  always @(negedge clk) begin
    if (rst_n) begin
      wd++;
      if (wd > 100000) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", outstanding, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
      for (int p = 0; p < N; p++) begin
        if (rsp_valid[p]) begin
          int t;
          logic [PA-1:0] e;
          t = int'(rsp_tag[p]);
          e = {xl(pva[t][31:12]), pva[t][11:0]};
          checks++;
          if (!pend[t] || pport[t] != p || rsp_paddr[p] != e) begin
            fails++;
            $display("FAIL R6 port %0d tag %0d actual=%0h expected=%0h pend=%0d", p, t,
                     rsp_paddr[p], e, pend[t]);
          end
          pend[t] = 1'b0;
          outstanding--;
          rlog[rcnt % 4096] = t;
          rcnt++;
        end
      end
      if (tq_h != tq_t && ($urandom % 2) == 0) begin
        tr_valid = 1'b1;
        tr_id    = tq_id[tq_h % 64];
        tr_ppn   = xl(tq_vpn[tq_h % 64]);
        tq_h++;
      end else begin
        tr_valid = 1'b0;
      end
      case (rdy_mode)
        1: lk_ready = 1'b0;
        2: lk_ready = 1'b1;
        default: lk_ready = ($urandom % 3) != 0;
      endcase
      if (lk_ready) begin
        for (int k = 0; k < P; k++) begin
          if (lk_valid[k]) begin
            tq_id[tq_t % 64]  = lk_id[k];
            tq_vpn[tq_t % 64] = lk_vpn[k];
            tq_t++;
            lk_total++;
          end
        end
      end
    end
  end

  // called at negedge+1 with requests on ports in en already driven
  task automatic push_reqs(input logic [N-1:0] en);
    logic [N-1:0] done;
    done = ~en;
    forever begin
      #1;
      for (int p = 0; p < N; p++) begin
        if (!done[p] && req_valid[p] && req_ready[p]) begin
          pend[req_tag[p]]  = 1'b1;
          pport[req_tag[p]] = p;
          pva[req_tag[p]]   = req_vaddr[p];
          outstanding++;
          acc_total++;
          done[p] = 1'b1;
        end
      end
      if (&done) break;
      @(negedge clk); #1;
      for (int p = 0; p < N; p++) if (done[p]) req_valid[p] = 1'b0;
    end
    @(negedge clk); #1;
    req_valid = '0;
  endtask

  task automatic send1(input int p, input logic [VA-1:0] va, input int tag, input int c);
    @(negedge clk); #1;
    req_valid[p] = 1'b1; req_vaddr[p] = va; req_tag[p] = TAG'(tag); req_cycle[p] = CYC'(c);
    push_reqs(N'(1) << p);
  endtask

  task automatic set_pair(input logic [VA-1:0] va0, input int c0, input int t0,
                          input logic [VA-1:0] va1, input int c1, input int t1);
    @(negedge clk); #1;
    req_valid = '1;
    req_vaddr[0] = va0; req_cycle[0] = CYC'(c0); req_tag[0] = TAG'(t0);
    req_vaddr[1] = va1; req_cycle[1] = CYC'(c1); req_tag[1] = TAG'(t1);
  endtask

  task automatic wait_idle();
    while (outstanding > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    #1;
  endtask

  int ptr [N];
  function automatic int pick_tag(input int p);
    for (int i = 0; i < 32; i++) begin
      int t;
      t = p * 32 + ((ptr[p] + i) % 32);
      if (!pend[t]) begin
        ptr[p] = (ptr[p] + i + 1) % 32;
        return t;
      end
    end
    return p * 32;
  endfunction

  task automatic rand_phase(input int n);
    logic [N-1:0] clr;
    clr = '0;
    for (int it = 0; it < n; it++) begin
      @(negedge clk); #1;
      for (int p = 0; p < N; p++) if (clr[p]) req_valid[p] = 1'b0;
      clr = '0;
      if (($urandom % 8) == 0) merge_dis = ~merge_dis;
      for (int p = 0; p < N; p++) begin
        if (!req_valid[p] && ($urandom % 3) != 0) begin
          int t, c;
          t = pick_tag(p);
          c = cyc - int'($urandom % 3);
          if (c < 0) c = 0;
          req_valid[p] = 1'b1;
          req_tag[p]   = TAG'(t);
          req_vaddr[p] = {20'(32'h100 + ($urandom % 4)), 12'($urandom)};
          req_cycle[p] = CYC'(c);
        end
      end
      #1;
      for (int p = 0; p < N; p++) begin
        if (req_valid[p] && req_ready[p]) begin
          pend[req_tag[p]]  = 1'b1;
          pport[req_tag[p]] = p;
          pva[req_tag[p]]   = req_vaddr[p];
          outstanding++;
          acc_total++;
          clr[p] = 1'b1;
        end
      end
    end
    @(negedge clk); #1;
    for (int p = 0; p < N; p++) if (clr[p]) req_valid[p] = 1'b0;
    merge_dis = 1'b0;
    if (|req_valid) push_reqs(req_valid);
  endtask

  initial begin
    int l0, r0;
    for (int i = 0; i < 64; i++) pend[i] = 1'b0;
    ptr[0] = 0; ptr[1] = 0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;

    // R10 reset state
    chk(lk_valid == '0, "R10 lk_valid", lk_valid, 0);
    chk(rsp_valid == '0, "R10 rsp_valid", rsp_valid, 0);
    chk(n_req == '0 && n_lkp == '0, "R10 counters", {n_req, n_lkp}, 0);
    // R8 single requester on port 1
    req_valid = 2'b10; req_vaddr[1] = 32'h0000_5004; req_tag[1] = 6'd40; req_cycle[1] = '0;
    #1;
    chk(req_ready == 2'b10, "R8 lone port1 ready", req_ready, 2'b10);
    push_reqs(2'b10);
    wait_idle();

    // R1 + R8 + R6: same page, same bucket, both ports
    rdy_mode = 2;
    l0 = int'(n_lkp); r0 = rcnt;
    set_pair(32'h1234_5678, 0, 1, 32'h1234_59AB, 0, 2);
    #1;
    chk(req_ready == 2'b01, "R8 priority", req_ready, 2'b01);
    push_reqs(2'b11);
    wait_idle();
    chk(int'(n_lkp) - l0 == 1, "R1 one lookup", int'(n_lkp) - l0, 1);
    chk(rlog[r0 % 4096] == 1 && rlog[(r0 + 1) % 4096] == 2, "R6 merge order",
        rlog[r0 % 4096], 1);

    // R2: same page, different buckets
    l0 = int'(n_lkp);
    set_pair(32'h2222_2010, 30, 3, 32'h2222_2020, 31, 4);
    push_reqs(2'b11);
    wait_idle();
    chk(int'(n_lkp) - l0 == 2, "R2 bucket split", int'(n_lkp) - l0, 2);

    // R4: merging off
    l0 = int'(n_lkp);
    merge_dis = 1'b1;
    set_pair(32'h3333_3010, 40, 5, 32'h3333_3020, 40, 6);
    push_reqs(2'b11);
    wait_idle();
    merge_dis = 1'b0;
    chk(int'(n_lkp) - l0 == 2, "R4 disabled merge", int'(n_lkp) - l0, 2);

    // R3 + R5: ordering by bucket then arrival, held while refused
    rdy_mode = 1;
    send1(0, 32'h00A0_0001, 7, 7);
    send1(0, 32'h00B0_0002, 8, 3);
    send1(0, 32'h00C0_0003, 9, 5);
    send1(0, 32'h00D0_0004, 10, 3);
    repeat (3) @(negedge clk); #1;
    chk(lk_valid == 2'b11, "R3 both lanes", lk_valid, 2'b11);
    chk(lk_vpn[0] == 20'h00B00, "R3 lane0 oldest", lk_vpn[0], 20'h00B00);
    chk(lk_vpn[1] == 20'h00D00, "R3 lane1 arrival", lk_vpn[1], 20'h00D00);
    chk(outstanding == 4, "R5 held lookups", outstanding, 4);
    rdy_mode = 2;
    @(negedge clk); @(negedge clk); #1;
    chk(lk_vpn[0] == 20'h00C00 && lk_valid[0], "R3 second lane0", lk_vpn[0], 20'h00C00);
    chk(lk_vpn[1] == 20'h00A00 && lk_valid[1], "R3 second lane1", lk_vpn[1], 20'h00A00);
    wait_idle();

    // R7 + R11: full merge slots and full table
    rdy_mode = 1;
    l0 = int'(n_lkp);
    for (int i = 0; i < 5; i++) send1(0, 32'h0100_0000 + 32'(i * 16), 11 + i, 20);
    send1(0, 32'h0200_0000, 16, 20);
    send1(1, 32'h0300_0000, 17, 20);
    @(negedge clk); #1;
    req_valid[0] = 1'b1; req_vaddr[0] = 32'h0400_0000; req_tag[0] = 6'd18; req_cycle[0] = 16'd20;
    #1;
    chk(req_ready == 2'b00, "R7 table full", req_ready, 0);
    repeat (3) @(negedge clk); #1;
    chk(req_ready == 2'b00, "R7 still full", req_ready, 0);
    rdy_mode = 2;
    push_reqs(2'b01);
    wait_idle();
    chk(int'(n_lkp) - l0 == 5, "R7 slot overflow opens entry", int'(n_lkp) - l0, 5);
    chk(outstanding == 0, "R11 drained", outstanding, 0);

    // random traffic
    rdy_mode = 0;
    rand_phase(800);
    wait_idle();
    chk(outstanding == 0, "R5 all answered", outstanding, 0);
    chk(int'(n_req) == acc_total, "R9 request count", n_req, acc_total);
    chk(int'(n_lkp) == lk_total, "R9 lookup count", n_lkp, lk_total);
    chk(lk_valid == '0, "R5 no stray lookup", lk_valid, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule